// File: doc/BRIEF.md
# Emulation Control-Store RAM Switch

This block wraps one RAM array that has two possible owners. In normal operation a host bus reads and writes it as 16-bit halfwords through a simple request/acknowledge handshake, which is how microcode gets loaded into it. When the emulation bit is set, the same array is handed to a microsequencer as its control store. The microsequencer uses an auxiliary port with a word address and full-width data. Reads on that port are registered, so their timing matches a fixed-latency microcode ROM and a loaded program runs exactly as it would from ROM.

While emulation is active the host is locked out. Any host request still completes, but it carries an error flag, returns zero and leaves the array unchanged. The emulation bit never changes while a host request is waiting. The request is completed under the old mode first. When emulation is off, the auxiliary port returns zero and ignores its write strobe.

Top module: `cs_ram_switch`

## Requirements
- R1: After a synchronous active-low reset, emu_on, host_ack and host_err are 0, and aux_rdata is zero.
- R2: Host halfword address host_addr selects word host_addr[ADDR_W:1]. host_addr[0]=0 selects data bits [31:16] and host_addr[0]=1 selects bits [15:0]. A host write changes only that halfword. A host read returns that halfword on host_rdata in the acknowledge cycle.
- R3: A host request that is held high is accepted at the first clock edge where host_ack is low. host_ack is high for exactly the one cycle after acceptance. host_rdata is zero in every cycle that is not a successful read acknowledge.
- R4: emu_on takes the value of cfg_emu at a clock edge only if no host request is pending at that edge. A request is pending when host_req is high and host_ack is low. Otherwise the mode change waits until the pending request has been accepted under the old mode.
- R5: A host request accepted while emu_on is 1 is acknowledged with host_err=1 and host_rdata zero, and a write leaves the array unchanged.
- R6: While emulation is active, aux_rdata shows the word at the aux_addr presented in cycle N during cycle N+1, with no wait states.
- R7: While emu_on is 1, aux_we writes the full aux_wdata word at aux_addr. A read of the same address in that cycle returns the previous contents.
- R8: While emu_on is 0, aux_rdata is zero and aux_we has no effect on the array.
- R9: Contents written by either owner are visible to the other owner after a mode switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_emu | input | 1 | Requested emulation mode bit |
| host_req | input | 1 | Host request, held until acknowledged |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W+1 | Host halfword address |
| host_wdata | input | 16 | Host write halfword |
| host_ack | output | 1 | One-cycle acknowledge |
| host_err | output | 1 | Error response, valid with host_ack |
| host_rdata | output | 16 | Host read halfword |
| aux_addr | input | ADDR_W | Auxiliary word address |
| aux_we | input | 1 | Auxiliary write strobe |
| aux_wdata | input | 32 | Auxiliary write word |
| aux_rdata | output | 32 | Auxiliary registered read word |
| emu_on | output | 1 | Current ownership: 1 means the auxiliary port owns the array |

## Verification
The bench builds the block with its default parameters: a 9-bit word address, 32-bit words and 16-bit host halfwords. This gives 512 words, so the first and last words of the array can both be reached through either port, and both halfword positions can be tested. It raises a host request and the emulation bit in the same cycle, so the deferred mode switch is observed. It also reads and writes one aux address in the same cycle, which exposes the read-before-write timing the ROM-equivalent path relies on.

// File: rtl/cs_ram_pkg.sv
// Package: shared helpers for the control-store RAM switch.
// Assumes halfword lanes are numbered from the least significant end of a word.
package cs_ram_pkg;

    // Ownership of the shared array.
    typedef enum logic {
        OWNER_HOST = 1'b0,
        OWNER_AUX  = 1'b1
    } owner_e;

    // Map a host halfword select to a lane index: select 0 is the most significant lane.
    function automatic int unsigned sel_to_lane(input int unsigned sel, input int unsigned lanes);
        return lanes - 1 - sel;
    endfunction

endpackage

// File: rtl/csr_mode_ctrl.sv
// Module: csr_mode_ctrl
// Holds the emulation ownership bit. It follows the requested mode only at an
// edge where no host request is pending. It also tracks whether the auxiliary
// read register holds data taken under auxiliary ownership.
// Assumes: host_pending is high exactly in cycles where a host request waits for acceptance.
module csr_mode_ctrl
    import cs_ram_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cfg_emu,
    input  logic   host_pending,
    output owner_e owner,
    output logic   aux_live
);

    logic aux_valid_q;

    // Update ownership only when no host request is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner <= OWNER_HOST;
        end else if (!host_pending) begin
            owner <= cfg_emu ? OWNER_AUX : OWNER_HOST;
        end
    end

    // Record that the read register was loaded under auxiliary ownership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux_valid_q <= 1'b0;
        end else begin
            aux_valid_q <= (owner == OWNER_AUX);
        end
    end

    // The auxiliary output is live only while the auxiliary port owns the array now and owned it last cycle.
    always_comb aux_live = aux_valid_q && (owner == OWNER_AUX);

endmodule

// File: rtl/csr_host_port.sv
// Module: csr_host_port
// Request/acknowledge adapter for host halfword access. It accepts a request
// when no acknowledge is showing, answers one cycle later, flags an error
// under auxiliary ownership, and produces per-lane write enables.
// Assumes: the array read register loads the host word at the accept edge.
module csr_host_port
    import cs_ram_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32,
    parameter int HALF_W = 16,
    localparam int LANES = DATA_W / HALF_W,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int HADDR_W = ADDR_W + SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [HALF_W-1:0]  host_wdata,
    input  owner_e             owner,
    input  logic [DATA_W-1:0]  rd_word,
    output logic               host_ack,
    output logic               host_err,
    output logic [HALF_W-1:0]  host_rdata,
    output logic               pending,
    output logic [LANES-1:0]   wr_lanes,
    output logic [ADDR_W-1:0]  word_addr,
    output logic [DATA_W-1:0]  wr_word
);

    logic             ack_q;
    logic             err_q;
    logic             we_q;
    logic [SEL_W-1:0] sel_q;
    logic             accept;

    // A request is pending, and is accepted, when no acknowledge is showing.
    always_comb accept  = host_req && !ack_q;
    always_comb pending = accept;

    // Word address and halfword replicated across all lanes.
    always_comb word_addr = host_addr[HADDR_W-1:SEL_W];
    always_comb wr_word   = {LANES{host_wdata}};

    // Write only the selected lane, and only under host ownership.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            wr_lanes[l] = accept && host_we && (owner == OWNER_HOST) &&
                          (sel_to_lane(int'(host_addr[SEL_W-1:0]), LANES) == l);
        end
    end

    // Capture the response attributes at the accept edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            err_q <= 1'b0;
            we_q  <= 1'b0;
            sel_q <= '0;
        end else begin
            ack_q <= accept;
            if (accept) begin
                err_q <= (owner == OWNER_AUX);
                we_q  <= host_we;
                sel_q <= host_addr[SEL_W-1:0];
            end
        end
    end

    // Return the selected halfword only on an error-free read acknowledge.
    always_comb begin
        host_rdata = '0;
        if (ack_q && !err_q && !we_q) begin
            host_rdata = rd_word[sel_to_lane(int'(sel_q), LANES)*HALF_W +: HALF_W];
        end
    end

    always_comb host_ack = ack_q;
    always_comb host_err = ack_q && err_q;

endmodule

// File: rtl/csr_store_array.sv
// Module: csr_store_array
// Single-port word array with per-lane write enables and a registered read.
// The read is read-first: a write in a cycle does not show in that cycle's read.
// Assumes: contents are not reset.
module csr_store_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32,
    parameter int HALF_W = 16,
    localparam int LANES = DATA_W / HALF_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  we_lanes,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_q
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Write the enabled lanes, then register the old word for reading.
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (we_lanes[l]) begin
                mem[addr][l*HALF_W +: HALF_W] <= wdata[l*HALF_W +: HALF_W];
            end
        end
        rdata_q <= mem[addr];
    end

endmodule

// File: rtl/cs_ram_switch.sv
// Module: cs_ram_switch (top)
// Shares one control-store array between a host halfword bus and an auxiliary
// word port. The mode bit selects which side drives the array address and write
// enables. The auxiliary port sees one-cycle registered reads.
// Assumes: the host holds host_req until it sees host_ack.
module cs_ram_switch
    import cs_ram_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32,
    parameter int HALF_W = 16,
    localparam int LANES = DATA_W / HALF_W,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int HADDR_W = ADDR_W + SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_emu,
    input  logic               host_req,
    input  logic               host_we,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [HALF_W-1:0]  host_wdata,
    output logic               host_ack,
    output logic               host_err,
    output logic [HALF_W-1:0]  host_rdata,
    input  logic [ADDR_W-1:0]  aux_addr,
    input  logic               aux_we,
    input  logic [DATA_W-1:0]  aux_wdata,
    output logic [DATA_W-1:0]  aux_rdata,
    output logic               emu_on
);

    owner_e            owner;
    logic              aux_live;
    logic              host_pending;
    logic [LANES-1:0]  host_lanes;
    logic [ADDR_W-1:0] host_word;
    logic [DATA_W-1:0] host_wword;
    logic [ADDR_W-1:0] arr_addr;
    logic [LANES-1:0]  arr_we;
    logic [DATA_W-1:0] arr_wdata;
    logic [DATA_W-1:0] arr_rdata;

    csr_mode_ctrl u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_emu      (cfg_emu),
        .host_pending (host_pending),
        .owner        (owner),
        .aux_live     (aux_live)
    );

    csr_host_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF_W(HALF_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .owner      (owner),
        .rd_word    (arr_rdata),
        .host_ack   (host_ack),
        .host_err   (host_err),
        .host_rdata (host_rdata),
        .pending    (host_pending),
        .wr_lanes   (host_lanes),
        .word_addr  (host_word),
        .wr_word    (host_wword)
    );

    // The owner drives the array address, write enables and write data.
    always_comb begin
        if (owner == OWNER_AUX) begin
            arr_addr  = aux_addr;
            arr_we    = {LANES{aux_we}};
            arr_wdata = aux_wdata;
        end else begin
            arr_addr  = host_word;
            arr_we    = host_lanes;
            arr_wdata = host_wword;
        end
    end

    csr_store_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF_W(HALF_W)) u_array (
        .clk      (clk),
        .addr     (arr_addr),
        .we_lanes (arr_we),
        .wdata    (arr_wdata),
        .rdata_q  (arr_rdata)
    );

    // The auxiliary output is zero unless the read register holds auxiliary data.
    always_comb aux_rdata = aux_live ? arr_rdata : '0;
    always_comb emu_on    = (owner == OWNER_AUX);

endmodule

// File: rtl/cs_ram_switch_checker.sv
// Module: cs_ram_switch_checker
// Port-level properties of the control-store switch, bound to the top module.
module cs_ram_switch_checker #(
    parameter int HALF_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_req,
    input logic              host_ack,
    input logic              host_err,
    input logic [HALF_W-1:0] host_rdata,
    input logic [DATA_W-1:0] aux_rdata,
    input logic              emu_on
);

    a_r3_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    a_r3_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ack |-> (host_rdata == '0));

    a_r4_hold_mode_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_ack) |=> $stable(emu_on));

    a_r5_err_matches_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_ack) |=> (host_ack && (host_err == $past(emu_on))));

    a_r5_err_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> (host_rdata == '0));

    a_r8_aux_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !emu_on |-> (aux_rdata == '0));

endmodule

bind cs_ram_switch cs_ram_switch_checker #(.HALF_W(HALF_W), .DATA_W(DATA_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_ack   (host_ack),
    .host_err   (host_err),
    .host_rdata (host_rdata),
    .aux_rdata  (aux_rdata),
    .emu_on     (emu_on)
);

// File: tb/cs_ram_switch_test.sv
// Directed bench for cs_ram_switch with default parameters.
module cs_ram_switch_test;

    localparam int ADDR_W = 9;
    localparam int DATA_W = 32;
    localparam int HALF_W = 16;
    localparam int HADDR_W = ADDR_W + 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_emu = 1'b0;
    logic               host_req = 1'b0;
    logic               host_we = 1'b0;
    logic [HADDR_W-1:0] host_addr = '0;
    logic [HALF_W-1:0]  host_wdata = '0;
    logic               host_ack;
    logic               host_err;
    logic [HALF_W-1:0]  host_rdata;
    logic [ADDR_W-1:0]  aux_addr = '0;
    logic               aux_we = 1'b0;
    logic [DATA_W-1:0]  aux_wdata = '0;
    logic [DATA_W-1:0]  aux_rdata;
    logic               emu_on;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cs_ram_switch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF_W(HALF_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_emu(cfg_emu),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ack(host_ack), .host_err(host_err),
        .host_rdata(host_rdata), .aux_addr(aux_addr), .aux_we(aux_we),
        .aux_wdata(aux_wdata), .aux_rdata(aux_rdata), .emu_on(emu_on)
    );

    task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One host access; checks acknowledge, error and read data.
    task automatic host_access(input string tag, input logic we, input logic [HADDR_W-1:0] a,
                               input logic [HALF_W-1:0] wd, input logic exp_err,
                               input logic [HALF_W-1:0] exp_rd);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = wd;
        @(negedge clk);
        check({tag, " ack"}, {31'b0, host_ack}, 32'd1);
        check({tag, " err"}, {31'b0, host_err}, {31'b0, exp_err});
        check({tag, " rdata"}, {16'b0, host_rdata}, {16'b0, exp_rd});
        host_req = 1'b0;
        @(negedge clk);
        check({tag, " ack drop"}, {31'b0, host_ack}, 32'd0);
    endtask

    // Change mode with no host traffic; ownership follows at the next edge.
    task automatic set_mode(input string tag, input logic m);
        @(negedge clk);
        cfg_emu = m;
        @(negedge clk);
        check({tag, " emu_on"}, {31'b0, emu_on}, {31'b0, m});
        @(negedge clk);
    endtask

    // Registered auxiliary read: address in one cycle, data in the next.
    task automatic aux_read(input string tag, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp);
        @(negedge clk);
        aux_addr = a;
        @(negedge clk);
        check(tag, aux_rdata, exp);
    endtask

    task automatic t_reset();
        check("R1 emu_on", {31'b0, emu_on}, 32'd0);
        check("R1 ack", {31'b0, host_ack}, 32'd0);
        check("R1 err", {31'b0, host_err}, 32'd0);
        check("R1 aux_rdata", aux_rdata, 32'd0);
    endtask

    task automatic t_host_halves();
        host_access("R2 wr hi w0", 1'b1, 10'd0, 16'h1234, 1'b0, 16'h0);
        host_access("R2 wr lo w0", 1'b1, 10'd1, 16'hABCD, 1'b0, 16'h0);
        host_access("R2 wr hi w511", 1'b1, 10'd1022, 16'hC3C3, 1'b0, 16'h0);
        host_access("R2 wr lo w511", 1'b1, 10'd1023, 16'h5A5A, 1'b0, 16'h0);
        host_access("R2 rd hi w0", 1'b0, 10'd0, 16'h0, 1'b0, 16'h1234);
        host_access("R2 rd lo w511", 1'b0, 10'd1023, 16'h0, 1'b0, 16'h5A5A);
        host_access("R3 rd lo w0", 1'b0, 10'd1, 16'h0, 1'b0, 16'hABCD);
    endtask

    task automatic t_aux_off();
        @(negedge clk);
        aux_addr = '0; aux_we = 1'b1; aux_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        aux_we = 1'b0;
        check("R8 aux_rdata off", aux_rdata, 32'd0);
        host_access("R8 host rd after aux_we", 1'b0, 10'd0, 16'h0, 1'b0, 16'h1234);
    endtask

    task automatic t_emu_reads_writes();
        set_mode("R4 enter", 1'b1);
        aux_read("R9 aux sees host w0", 9'd0, 32'h1234_ABCD);
        aux_read("R6 aux w511", 9'd511, 32'hC3C3_5A5A);
        @(negedge clk);
        aux_addr = 9'd0; aux_we = 1'b1; aux_wdata = 32'hCAFE_F00D;
        @(negedge clk);
        aux_we = 1'b0;
        check("R7 read-first", aux_rdata, 32'h1234_ABCD);
        @(negedge clk);
        check("R7 new word", aux_rdata, 32'hCAFE_F00D);
    endtask

    task automatic t_host_locked();
        host_access("R5 wr in emu", 1'b1, 10'd1, 16'h0000, 1'b1, 16'h0);
        host_access("R5 rd in emu", 1'b0, 10'd0, 16'h0, 1'b1, 16'h0);
        aux_read("R5 no write", 9'd0, 32'hCAFE_F00D);
    endtask

    task automatic t_leave();
        set_mode("R4 leave", 1'b0);
        check("R8 aux zero after leave", aux_rdata, 32'd0);
        host_access("R9 host hi", 1'b0, 10'd0, 16'h0, 1'b0, 16'hCAFE);
        host_access("R9 host lo", 1'b0, 10'd1, 16'h0, 1'b0, 16'hF00D);
    endtask

    task automatic t_deferred();
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_addr = 10'd1022; cfg_emu = 1'b1;
        @(negedge clk);
        check("R4 deferred emu_on", {31'b0, emu_on}, 32'd0);
        check("R4 deferred ack", {31'b0, host_ack}, 32'd1);
        check("R4 deferred err", {31'b0, host_err}, 32'd0);
        check("R4 deferred rdata", {16'b0, host_rdata}, 32'h0000_C3C3);
        host_req = 1'b0;
        @(negedge clk);
        check("R4 switched after", {31'b0, emu_on}, 32'd1);
        set_mode("R4 exit", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_host_halves();
        t_aux_off();
        t_emu_reads_writes();
        t_host_locked();
        t_leave();
        t_deferred();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule